// File: doc/BRIEF.md
# Edge-Sensing GPIO Controller

This block is a register-mapped general-purpose I/O controller for 28 pins, each pin owning the bit of the same index in every register. A simple 32-bit register bus (byte address, write enable, write data, combinational read data) gives software control of pin direction, the output latch, the per-pin edge sensing, and a per-pin alternate-function selector. The block does not drive pads. It presents output-enable and output-value vectors, and a separate pad ring turns them into tri-state drivers.

Each pin input passes through a two-flop synchronizer. An edge is found by comparing the synchronized level with its value one cycle earlier. An edge that is enabled for its direction sets a sticky status bit, and that bit stays set until software writes a one to it. Pins 0 to 10 each drive an interrupt line of their own. Pins 11 to 27 share a single line.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset every register reads zero, `pin_oe`, `pin_out`, `alt_sel` are all zero and no interrupt is asserted.
- R2: A write to byte offset 0x08 drives the output latch high on every bit written as 1 and leaves the bits written as 0 unchanged. Offset 0x08 always reads zero.
- R3: A write to byte offset 0x0C drives the output latch low on every bit written as 1 and leaves the bits written as 0 unchanged. Offset 0x0C always reads zero.
- R4: The direction register at offset 0x04 appears on `pin_oe`, where 1 means the pin is an output. Writing this register never changes the output latch, and the latch is always visible on `pin_out`.
- R5: Offset 0x00 reads the synchronized level of every pin whatever its direction. A change on `pin_in` becomes visible there two clock edges later.
- R6: When rising enable (offset 0x10) is set for a pin, a low-to-high transition of that pin sets its status bit at offset 0x18, three clock edges after the input changes. Without that enable, the transition sets nothing.
- R7: When falling enable (offset 0x14) is set for a pin, a high-to-low transition sets its status bit. When both enables are set, either transition sets the bit.
- R8: Writing ones to offset 0x18 clears those status bits and writing zeros has no effect. Writing back a value read earlier therefore leaves pending any edge that arrived after that read.
- R9: If a qualifying edge and a clearing write reach the same status bit in the same cycle, the bit remains set.
- R10: `irq_direct[i]` for i in 0..10 equals status bit i.
- R11: `irq_shared` is the OR of status bits 11 to 27.
- R12: The alternate-function register at offset 0x1C holds bits 0..27, appears on `alt_sel`, and reads back with bits 28..31 zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 5 | Byte address of the register; bits 4..2 select it |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | 28 | Raw pin levels from the pads, asynchronous |
| pin_oe | output | 28 | Output enable per pin (direction register) |
| pin_out | output | 28 | Output latch value per pin |
| alt_sel | output | 28 | Alternate-function selection per pin |
| irq_direct | output | 11 | Interrupt lines for pins 0 to 10 |
| irq_shared | output | 1 | Combined interrupt for pins 11 to 27 |

## Verification
Two things can act on the same status bit in the same cycle: a newly detected edge and a one written to the status register. The bench sets this up by timing a falling transition so that its detection cycle, two clock edges after the pin change, coincides with a write that clears that bit. It then reads the bit back and expects it still set, because the edge wins. A second test targets a related race. Status is read, an edge on a different pin arrives, and the old value is written back. Only the new pin's bit may remain, and its interrupt must still be asserted.

// File: rtl/gpio_edge_pkg.sv
// Shared definitions for the edge-sensing GPIO controller.
// Assumes a 32-bit register bus whose word index sits in address bits 4..2.
package gpio_edge_pkg;

    // Register selector decoded from the word index of the byte address.
    typedef enum logic [2:0] {
        SEL_LEVEL = 3'd0,   // 0x00 synchronized pin level, read only
        SEL_DIR   = 3'd1,   // 0x04 direction, 1 = output
        SEL_SET   = 3'd2,   // 0x08 write ones to drive latch high
        SEL_CLR   = 3'd3,   // 0x0C write ones to drive latch low
        SEL_RISE  = 3'd4,   // 0x10 rising-edge enable
        SEL_FALL  = 3'd5,   // 0x14 falling-edge enable
        SEL_STAT  = 3'd6,   // 0x18 sticky edge status, write one to clear
        SEL_ALT   = 3'd7    // 0x1C alternate-function select
    } reg_sel_e;

    localparam int SEL_W   = 3;
    localparam int SEL_LSB = 2;

endpackage

// File: rtl/gpio_pin_sync.sv
// Two-flop synchronizer, one chain per pin.
// Assumes the pin inputs are asynchronous and that the second stage is
// the only one that downstream logic reads.
module gpio_pin_sync #(
    parameter int W = 28
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_in,
    output logic [W-1:0] sync_out
);

    genvar g;
    generate
        for (g = 0; g < W; g++) begin : g_chain
            logic meta_q;
            logic stable_q;

            // Carry one pin through two flops into the clock domain.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    meta_q   <= 1'b0;
                    stable_q <= 1'b0;
                end else begin
                    meta_q   <= raw_in[g];
                    stable_q <= meta_q;
                end
            end

            assign sync_out[g] = stable_q;
        end
    endgenerate

endmodule

// File: rtl/gpio_edge_status.sv
// Edge detector and sticky status register.
// It compares the synchronized level with its previous value and, for each
// pin, qualifies the transition with that pin's rising and falling enables.
// A qualified edge sets the status bit, and clr_mask clears bits. When both
// act on the same bit in the same cycle, the edge takes precedence.
// Assumes level_in is already synchronous to clk.
module gpio_edge_status #(
    parameter int W = 28
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] level_in,
    input  logic [W-1:0] rise_en,
    input  logic [W-1:0] fall_en,
    input  logic [W-1:0] clr_mask,
    output logic [W-1:0] status
);

    logic [W-1:0] level_prev;
    logic [W-1:0] rise_seen;
    logic [W-1:0] fall_seen;
    logic [W-1:0] edge_evt;

    // Classify the transition of each pin and apply the per-pin enables.
    always_comb begin
        rise_seen = level_in & ~level_prev;
        fall_seen = ~level_in & level_prev;
        edge_evt  = (rise_seen & rise_en) | (fall_seen & fall_en);
    end

    // Remember the level and update the status: clear first, then set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_prev <= '0;
            status     <= '0;
        end else begin
            level_prev <= level_in;
            status     <= (status & ~clr_mask) | edge_evt;
        end
    end

    AST_EDGE_CAPTURED: assert property (@(posedge clk) disable iff (!rst_n)
        (|edge_evt) |=> ((status & $past(edge_evt)) == $past(edge_evt))); // R9

    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_mask == '0) |=> ((status & $past(status)) == $past(status))); // R8

endmodule

// File: rtl/gpio_regfile.sv
// Register file and bus decoder.
// It holds the direction, output latch, edge enables and alternate-function
// registers, generates the status clear mask from writes to the status
// offset, and multiplexes read data. The set and clear offsets change only
// the latch and read back zero.
// Assumes one bus access per cycle and a combinational read.
module gpio_regfile
    import gpio_edge_pkg::*;
#(
    parameter int W      = 28,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [W-1:0]      level_in,
    input  logic [W-1:0]      status_in,
    output logic [W-1:0]      dir_q,
    output logic [W-1:0]      latch_q,
    output logic [W-1:0]      rise_q,
    output logic [W-1:0]      fall_q,
    output logic [W-1:0]      alt_q,
    output logic [W-1:0]      clr_mask
);

    localparam int PAD_W = DATA_W - W;

    reg_sel_e     sel;
    logic [W-1:0] wbits;
    logic [W-1:0] rd_val;
    logic         unused_bus_bits;

    // Decode the register selector and the pin-sized slice of write data.
    always_comb begin
        sel   = reg_sel_e'(bus_addr[SEL_LSB +: SEL_W]);
        wbits = bus_wdata[W-1:0];
    end

    assign unused_bus_bits = ^{bus_addr[SEL_LSB-1:0], bus_wdata[DATA_W-1:W]};

    // Write-one-to-clear mask presented to the status register.
    always_comb begin
        clr_mask = (bus_we && sel == SEL_STAT) ? wbits : '0;
    end

    // Update the writable registers and the output latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q   <= '0;
            latch_q <= '0;
            rise_q  <= '0;
            fall_q  <= '0;
            alt_q   <= '0;
        end else if (bus_we) begin
            case (sel)
                SEL_DIR:  dir_q   <= wbits;
                SEL_SET:  latch_q <= latch_q | wbits;
                SEL_CLR:  latch_q <= latch_q & ~wbits;
                SEL_RISE: rise_q  <= wbits;
                SEL_FALL: fall_q  <= wbits;
                SEL_ALT:  alt_q   <= wbits;
                default:  ;
            endcase
        end
    end

    // Select read data; the set and clear offsets have no readable state.
    always_comb begin
        case (sel)
            SEL_LEVEL: rd_val = level_in;
            SEL_DIR:   rd_val = dir_q;
            SEL_RISE:  rd_val = rise_q;
            SEL_FALL:  rd_val = fall_q;
            SEL_STAT:  rd_val = status_in;
            SEL_ALT:   rd_val = alt_q;
            default:   rd_val = '0;
        endcase
        bus_rdata = {{PAD_W{1'b0}}, rd_val};
    end

    AST_SET_DRIVES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && sel == SEL_SET) |=>
        ((latch_q & $past(wbits)) == $past(wbits))); // R2

    AST_CLR_DRIVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && sel == SEL_CLR) |=> ((latch_q & $past(wbits)) == '0)); // R3

    AST_DIR_KEEPS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && sel == SEL_DIR) |=> $stable(latch_q)); // R4

endmodule

// File: rtl/gpio_irq_split.sv
// Interrupt fan-out.
// The low pins each get a line of their own, and the remaining pins are
// OR-reduced onto one shared line.
// Assumes N_DIRECT is at least 1 and below W.
module gpio_irq_split #(
    parameter int W        = 28,
    parameter int N_DIRECT = 11
) (
    input  logic [W-1:0]        status,
    output logic [N_DIRECT-1:0] irq_direct,
    output logic                irq_shared
);

    genvar g;
    generate
        for (g = 0; g < N_DIRECT; g++) begin : g_direct
            assign irq_direct[g] = status[g];
        end
    endgenerate

    // Combine the upper pins into the shared interrupt.
    always_comb begin
        irq_shared = |status[W-1:N_DIRECT];
    end

endmodule

// File: rtl/gpio_edge_ctrl.sv
// Top level of the edge-sensing GPIO controller.
// It connects the synchronizer, edge and status logic, register file and
// interrupt fan-out, and exposes pad controls as plain vectors.
// Assumes synchronous active-low reset and one bus access per cycle.
module gpio_edge_ctrl #(
    parameter int N_PINS   = 28,
    parameter int N_DIRECT = 11,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_we,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [N_PINS-1:0]   pin_in,
    output logic [N_PINS-1:0]   pin_oe,
    output logic [N_PINS-1:0]   pin_out,
    output logic [N_PINS-1:0]   alt_sel,
    output logic [N_DIRECT-1:0] irq_direct,
    output logic                irq_shared
);

    logic [N_PINS-1:0] level_s;
    logic [N_PINS-1:0] status_s;
    logic [N_PINS-1:0] rise_s;
    logic [N_PINS-1:0] fall_s;
    logic [N_PINS-1:0] clr_s;

    gpio_pin_sync #(.W(N_PINS)) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_in   (pin_in),
        .sync_out (level_s)
    );

    gpio_regfile #(.W(N_PINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .level_in  (level_s),
        .status_in (status_s),
        .dir_q     (pin_oe),
        .latch_q   (pin_out),
        .rise_q    (rise_s),
        .fall_q    (fall_s),
        .alt_q     (alt_sel),
        .clr_mask  (clr_s)
    );

    gpio_edge_status #(.W(N_PINS)) stat_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .level_in (level_s),
        .rise_en  (rise_s),
        .fall_en  (fall_s),
        .clr_mask (clr_s),
        .status   (status_s)
    );

    gpio_irq_split #(.W(N_PINS), .N_DIRECT(N_DIRECT)) irq_i (
        .status     (status_s),
        .irq_direct (irq_direct),
        .irq_shared (irq_shared)
    );

    AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!irq_shared && irq_direct == '0)); // R1

endmodule

// File: tb/gpio_edge_ctrl_tb_top.sv
`timescale 1ns/1ps
// Self-checking bench: per-pin sweeps of edge sensing and interrupt routing,
// plus latch, direction, level and clear-race checks.
module gpio_edge_ctrl_tb_top;

    localparam int          NP    = 28;
    localparam logic [31:0] PMASK = 32'h0FFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [4:0]  bus_addr;
    logic        bus_we;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [27:0] pin_in;
    logic [27:0] pin_oe;
    logic [27:0] pin_out;
    logic [27:0] alt_sel;
    logic [10:0] irq_direct;
    logic        irq_shared;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    gpio_edge_ctrl dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_we     (bus_we),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .pin_in     (pin_in),
        .pin_oe     (pin_oe),
        .pin_out    (pin_out),
        .alt_sel    (alt_sel),
        .irq_direct (irq_direct),
        .irq_shared (irq_shared)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] keep;
        logic [31:0] lat;
        rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0; pin_in = '0;
        settle(3);
        // R1: reset state
        for (int r = 0; r < 8; r++) begin
            rd(5'(r * 4), v);
            check("R1 register reset", v, 32'd0);
        end
        check("R1 pin_oe reset", {4'b0, pin_oe}, 32'd0);
        check("R1 pin_out reset", {4'b0, pin_out}, 32'd0);
        check("R1 alt_sel reset", {4'b0, alt_sel}, 32'd0);
        check("R1 irq reset", {20'b0, irq_shared, irq_direct}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R6, R10, R11: rising sweep across every pin
        wr(5'h10, PMASK);
        wr(5'h14, 32'd0);
        for (int i = 0; i < NP; i++) begin
            pin_in = 28'(1) << i;
            settle(3);
            rd(5'h18, v);
            check("R6 rising edge captured", v, 32'(1) << i);
            check("R10 direct irq", {21'b0, irq_direct}, (i < 11) ? (32'(1) << i) : 32'd0);
            check("R11 shared irq", {31'b0, irq_shared}, 32'(i >= 11));
            wr(5'h18, 32'(1) << i);
            rd(5'h18, v);
            check("R8 write one clears", v, 32'd0);
            pin_in = '0;
            settle(3);
            rd(5'h18, v);
            check("R7 falling ignored without enable", v, 32'd0);
        end

        // R7: falling sweep, rising disabled
        wr(5'h10, 32'd0);
        wr(5'h14, PMASK);
        pin_in = '1;
        settle(3);
        rd(5'h18, v);
        check("R6 rising ignored without enable", v, 32'd0);
        for (int i = 0; i < NP; i++) begin
            pin_in[i] = 1'b0;
            settle(3);
            rd(5'h18, v);
            check("R7 falling edge captured", v, 32'(1) << i);
            wr(5'h18, PMASK);
            pin_in[i] = 1'b1;
            settle(3);
            rd(5'h18, v);
            check("R7 rising not captured", v, 32'd0);
        end
        pin_in = '0;
        settle(3);
        wr(5'h18, PMASK);

        // R7: both enables detect either edge
        wr(5'h10, PMASK);
        pin_in = 28'(1) << 5;
        settle(3);
        rd(5'h18, v);
        check("R7 both enables rising", v, 32'h20);
        wr(5'h18, 32'h20);
        pin_in = '0;
        settle(3);
        rd(5'h18, v);
        check("R7 both enables falling", v, 32'h20);
        wr(5'h18, PMASK);
        wr(5'h14, 32'd0);

        // R8: zeros do not clear; stale write-back keeps the newer edge
        pin_in = (28'(1) << 3) | (28'(1) << 20);
        settle(3);
        wr(5'h18, 32'h8);
        rd(5'h18, v);
        check("R8 partial clear", v, 32'(1) << 20);
        wr(5'h18, 32'd0);
        rd(5'h18, v);
        check("R8 zero write no effect", v, 32'(1) << 20);
        keep = v;
        pin_in[7] = 1'b1;
        settle(3);
        wr(5'h18, keep);
        rd(5'h18, v);
        check("R8 later edge stays pending", v, 32'h80);
        check("R8 irq still asserted", {31'b0, irq_direct[7]}, 32'd1);
        wr(5'h18, PMASK);
        pin_in = '0;
        settle(3);

        // R9: edge detection coincides with a clearing write
        wr(5'h14, PMASK);
        pin_in = 28'(1) << 9;
        settle(3);
        rd(5'h18, v);
        check("R9 setup status", v, 32'h200);
        pin_in = '0;
        settle(2);
        bus_addr = 5'h18; bus_wdata = 32'h200; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        rd(5'h18, v);
        check("R9 edge wins over clear", v, 32'h200);
        wr(5'h18, 32'h200);
        rd(5'h18, v);
        check("R9 later clear works", v, 32'd0);
        wr(5'h10, 32'd0);
        wr(5'h14, 32'd0);

        // R2, R3: set and clear latch
        lat = 32'h0A5A_5A5A;
        wr(5'h08, lat);
        check("R2 set from zero", {4'b0, pin_out}, lat);
        wr(5'h08, 32'h0000_0005);
        lat = lat | 32'h5;
        check("R2 set keeps other bits", {4'b0, pin_out}, lat);
        wr(5'h0C, 32'h0000_000F);
        lat = lat & ~32'hF;
        check("R3 clear ones only", {4'b0, pin_out}, lat);
        wr(5'h0C, 32'd0);
        check("R3 zero clear no effect", {4'b0, pin_out}, lat);
        rd(5'h08, v);
        check("R2 set offset reads zero", v, 32'd0);
        rd(5'h0C, v);
        check("R3 clear offset reads zero", v, 32'd0);

        // R4: direction
        wr(5'h04, 32'h00F0_F0F0);
        check("R4 oe follows direction", {4'b0, pin_oe}, 32'h00F0_F0F0);
        check("R4 latch unchanged", {4'b0, pin_out}, lat);
        rd(5'h04, v);
        check("R4 direction readback", v, 32'h00F0_F0F0);

        // R5: level readback regardless of direction
        for (int k = 0; k < 8; k++) begin
            logic [31:0] pat;
            pat = (32'(k + 1) * 32'h0249_2493) & PMASK;
            if (k == 4) wr(5'h04, PMASK);
            pin_in = pat[27:0];
            settle(2);
            rd(5'h00, v);
            check("R5 level readback", v, pat);
        end
        pin_in = '0;

        // R12: alternate function
        wr(5'h1C, 32'hFFFF_FFFF);
        rd(5'h1C, v);
        check("R12 alt readback", v, PMASK);
        check("R12 alt output", {4'b0, alt_sel}, PMASK);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule